// File: doc/BRIEF.md
# Offline Converter Protection Supervisor

This block sequences the supply and handles faults for an offline flyback PWM controller. Its inputs are already digitized comparator flags: the supply is above its turn-on level, above its PWM-off level, and above its shutdown level. Further flags report supply over-voltage, feedback above the open-loop threshold, output over-voltage seen on the detect pin, and over-temperature. The block also receives the present gate state and an asynchronous power-removed reset. From these it drives the high-voltage startup current source, the PWM enable, a soft-start ramp value and a latched-fault indication with its cause.

There are three supply lockout levels. Losing the PWM-off level stops switching. The controller restarts only after the supply falls below the shutdown level and then recharges to the turn-on level. An open-loop fault uses the same path, so it recovers on its own. Supply over-voltage, output over-voltage and over-temperature latch the controller off until power is removed. All delays are parameters counted in clock cycles.

Top module: `prot_supervisor`

## Requirements
- R1: `hv_en` is high while `state` is OFF or STARTUP and `sup_on` is low. It falls in the same cycle that `sup_on` is seen high. It is low in every other state.
- R2: `state` uses the codes OFF=0, STARTUP=1, SOFTSTART=2, RUN=3, PWM_OFF=4, LATCHED=5. OFF moves to STARTUP when `sup_run` is high. STARTUP moves to SOFTSTART when `sup_on` is high, and returns to OFF if `sup_run` is lost.
- R3: On every entry to SOFTSTART, `ss_level` is 0. It then rises by one per cycle up to `SS_CYCLES`. In the cycle after it reaches `SS_CYCLES`, the state becomes RUN and `ss_level` holds that value. `pwm_en` is high only in SOFTSTART and RUN.
- R4: If `sup_pwm` is low in SOFTSTART or RUN, the next state is PWM_OFF and `pwm_en` goes low. PWM_OFF leaves only for OFF, when `sup_run` is lost. A return of `sup_pwm` during PWM_OFF does not re-enable PWM.
- R5: `fb_open` high for `OLP_CYCLES` consecutive cycles in SOFTSTART or RUN moves the state to PWM_OFF. A single low cycle restarts the count.
- R6: `sup_ovp` high for `OVP_CYCLES` consecutive cycles in SOFTSTART or RUN moves the state to LATCHED and sets bit 0 of `fault_cause`. A single low cycle restarts the count.
- R7: `out_ovp` is sampled only while `gate` is low and at least the blanking count has elapsed since `gate` fell. The blanking count is `BLANK_SLOW` when `FAST`=0 and `BLANK_FAST` when `FAST`=1. `OVP_CYCLES` consecutive high samples latch the block with bit 1 of `fault_cause` set. A low sample restarts the count. Gate-high and blanking cycles leave the count unchanged.
- R8: `otp` high in SOFTSTART or RUN latches the block at the next edge and sets bit 2 of `fault_cause`.
- R9: LATCHED ignores every input except `rst_n`. In LATCHED, `fault_latched` is high, `pwm_en` and `hv_en` are low, and `fault_cause` is held. `fault_cause` is 0 before any latch. Causes that trip in the same cycle are all recorded. A latching fault takes priority over an open-loop trip or a PWM-off crossing in the same cycle.
- R10: Fault flags are monitored only in SOFTSTART and RUN. In any other state they have no effect, and all debounce counts are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-removed reset, asynchronous, active low |
| sup_on | input | 1 | Supply above the turn-on level |
| sup_pwm | input | 1 | Supply above the PWM-off level |
| sup_run | input | 1 | Supply above the shutdown level |
| sup_ovp | input | 1 | Supply over-voltage flag |
| fb_open | input | 1 | Feedback above the open-loop threshold |
| out_ovp | input | 1 | Output over-voltage flag from the detect pin |
| otp | input | 1 | Over-temperature flag |
| gate | input | 1 | Present gate drive state |
| hv_en | output | 1 | Startup current source enable |
| pwm_en | output | 1 | PWM enable |
| ss_level | output | SS_W | Soft-start ramp value |
| fault_latched | output | 1 | Latched fault present |
| fault_cause | output | 3 | Latched cause: bit 0 supply OVP, bit 1 output OVP, bit 2 over-temperature |
| state | output | 3 | Sequencer state code |

## Verification
The assertions assume that every flag is synchronous to `clk` and already filtered upstream. They also assume that only `rst_n` can leave LATCHED. The stimulus changes inputs only on falling clock edges. It keeps the supply flags nested: turn-on implies PWM-off, and PWM-off implies shutdown. It raises and lowers them in the order a real supply would cross them. The gate toggles in bursts, so output over-voltage samples fall both inside and outside the blanking window. Short glitches in each fault flag exercise the counter restarts before any fault is held long enough to trip.

// File: rtl/prot_supervisor.sv
module prot_supervisor #(
  parameter int SS_CYCLES  = 50000,
  parameter int OLP_CYCLES = 520000,
  parameter int OVP_CYCLES = 1500,
  parameter int BLANK_SLOW = 40,
  parameter int BLANK_FAST = 15,
  parameter bit FAST       = 1'b0,
  localparam int SS_W      = $clog2(SS_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sup_on,
  input  logic            sup_pwm,
  input  logic            sup_run,
  input  logic            sup_ovp,
  input  logic            fb_open,
  input  logic            out_ovp,
  input  logic            otp,
  input  logic            gate,
  output logic            hv_en,
  output logic            pwm_en,
  output logic [SS_W-1:0] ss_level,
  output logic            fault_latched,
  output logic [2:0]      fault_cause,
  output logic [2:0]      state
);
  localparam int BLANK = FAST ? BLANK_FAST : BLANK_SLOW;
  localparam int OL_W  = $clog2(OLP_CYCLES + 1);
  localparam int OV_W  = $clog2(OVP_CYCLES + 1);
  localparam int BL_W  = $clog2(BLANK + 1);

  typedef enum logic [2:0] {
    S_OFF = 3'd0, S_START = 3'd1, S_SOFT = 3'd2,
    S_RUN = 3'd3, S_PWMOFF = 3'd4, S_LATCH = 3'd5
  } st_t;

  st_t st, st_nx;
  logic [SS_W-1:0] ss_cnt;
  logic [OL_W-1:0] olp_cnt;
  logic [OV_W-1:0] vov_cnt, oov_cnt;
  logic [BL_W-1:0] blank_cnt;
  logic [2:0]      cause_q;

  wire active   = (st == S_SOFT) || (st == S_RUN);
  wire window   = !gate && (blank_cnt == BL_W'(BLANK));
  wire vdd_trip = active && sup_ovp && (vov_cnt == OV_W'(OVP_CYCLES - 1));
  wire out_trip = active && window && out_ovp && (oov_cnt == OV_W'(OVP_CYCLES - 1));
  wire olp_trip = active && fb_open && (olp_cnt == OL_W'(OLP_CYCLES - 1));
  wire latch_now = active && (otp || vdd_trip || out_trip);

  always_comb begin
    st_nx = st;
    case (st)
      S_OFF:    if (sup_run) st_nx = S_START;
      S_START:  if (!sup_run) st_nx = S_OFF;
                else if (sup_on) st_nx = S_SOFT;
      S_SOFT, S_RUN:
                if (latch_now) st_nx = S_LATCH;
                else if (olp_trip || !sup_pwm) st_nx = S_PWMOFF;
                else if (st == S_SOFT && ss_cnt == SS_W'(SS_CYCLES)) st_nx = S_RUN;
      S_PWMOFF: if (!sup_run) st_nx = S_OFF;
      default:  st_nx = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OFF;
      ss_cnt    <= '0;
      olp_cnt   <= '0;
      vov_cnt   <= '0;
      oov_cnt   <= '0;
      blank_cnt <= '0;
      cause_q   <= '0;
    end else begin
      st <= st_nx;
      if (st_nx == S_SOFT)     ss_cnt <= (st == S_SOFT) ? ss_cnt + 1'b1 : '0;
      else if (st_nx == S_RUN) ss_cnt <= SS_W'(SS_CYCLES);
      else                     ss_cnt <= '0;
      if (!(active && fb_open))                olp_cnt <= '0;
      else if (olp_cnt != OL_W'(OLP_CYCLES))   olp_cnt <= olp_cnt + 1'b1;
      if (!(active && sup_ovp))                vov_cnt <= '0;
      else if (vov_cnt != OV_W'(OVP_CYCLES))   vov_cnt <= vov_cnt + 1'b1;
      if (!active)                             oov_cnt <= '0;
      else if (window && !out_ovp)             oov_cnt <= '0;
      else if (window && oov_cnt != OV_W'(OVP_CYCLES)) oov_cnt <= oov_cnt + 1'b1;
      if (gate)                                blank_cnt <= '0;
      else if (blank_cnt != BL_W'(BLANK))      blank_cnt <= blank_cnt + 1'b1;
      if (latch_now && st != S_LATCH)          cause_q <= {otp, out_trip, vdd_trip};
    end
  end

  assign hv_en         = (st == S_OFF || st == S_START) && !sup_on;
  assign pwm_en        = active;
  assign ss_level      = ss_cnt;
  assign fault_latched = (st == S_LATCH);
  assign fault_cause   = cause_q;
  assign state         = st;

  AST_HV_QUIET_WHEN_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |-> !hv_en); // R1
  AST_SS_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en) |-> ss_level == '0); // R3
  AST_UV_DROPS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sup_pwm) |=> !pwm_en); // R4
  AST_OTP_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (active && otp) |=> fault_latched); // R8
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |=> fault_latched && !pwm_en && !hv_en && $stable(fault_cause)); // R9
  AST_CAUSE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> fault_cause != 3'd0); // R9
endmodule

// File: tb/prot_supervisor_test.sv
module prot_supervisor_test;
  localparam int SS = 8, OLP = 20, OVP = 6, BSLOW = 5, BFAST = 2;
  localparam bit FAST = 1'b0;
  localparam int BLANK = FAST ? BFAST : BSLOW;
  localparam int SSW = $clog2(SS + 1);

  logic clk = 1'b0, rst_n = 1'b1;
  logic sup_on = 0, sup_pwm = 0, sup_run = 0, sup_ovp = 0, fb_open = 0, out_ovp = 0, otp = 0, gate = 0;
  logic hv_en, pwm_en, fault_latched;
  logic [SSW-1:0] ss_level;
  logic [2:0] fault_cause, state;

  int checks = 0, errors = 0;
  string cur_req = "R2";

  prot_supervisor #(.SS_CYCLES(SS), .OLP_CYCLES(OLP), .OVP_CYCLES(OVP),
                    .BLANK_SLOW(BSLOW), .BLANK_FAST(BFAST), .FAST(FAST)) uut (
    .clk(clk), .rst_n(rst_n), .sup_on(sup_on), .sup_pwm(sup_pwm), .sup_run(sup_run),
    .sup_ovp(sup_ovp), .fb_open(fb_open), .out_ovp(out_ovp), .otp(otp), .gate(gate),
    .hv_en(hv_en), .pwm_en(pwm_en), .ss_level(ss_level), .fault_latched(fault_latched),
    .fault_cause(fault_cause), .state(state));

  always #10 clk = ~clk;

  // behavioural reference model
  int m_st = 0, m_ss = 0, m_olp = 0, m_vov = 0, m_oov = 0, m_blank = 0, m_cause = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ss = 0; m_olp = 0; m_vov = 0; m_oov = 0; m_blank = 0; m_cause = 0;
    end else begin
      bit act, win, vt, ot, lt;
      int nx;
      act = (m_st == 2 || m_st == 3);
      win = !gate && (m_blank >= BLANK);
      vt  = act && sup_ovp && (m_vov + 1 >= OVP);
      ot  = act && win && out_ovp && (m_oov + 1 >= OVP);
      lt  = act && fb_open && (m_olp + 1 >= OLP);
      nx  = m_st;
      if (m_st == 0 && sup_run) nx = 1;
      else if (m_st == 1) begin
        if (!sup_run) nx = 0; else if (sup_on) nx = 2;
      end else if (act) begin
        if (otp || vt || ot) begin
          nx = 5;
          m_cause = (otp ? 4 : 0) + (ot ? 2 : 0) + (vt ? 1 : 0);
        end else if (lt || !sup_pwm) nx = 4;
        else if (m_st == 2 && m_ss >= SS) nx = 3;
      end else if (m_st == 4 && !sup_run) nx = 0;
      m_vov = (act && sup_ovp) ? m_vov + 1 : 0;
      m_olp = (act && fb_open) ? m_olp + 1 : 0;
      if (!act) m_oov = 0;
      else if (win) m_oov = out_ovp ? m_oov + 1 : 0;
      m_blank = gate ? 0 : m_blank + 1;
      if (nx == 2) m_ss = (m_st == 2) ? m_ss + 1 : 0;
      else if (nx == 3) m_ss = SS;
      else m_ss = 0;
      m_st = nx;
    end
  end

  task automatic compare();
    bit e_hv, e_pwm, e_lat;
    e_hv  = (m_st <= 1) && !sup_on;
    e_pwm = (m_st == 2 || m_st == 3);
    e_lat = (m_st == 5);
    checks++;
    if (state !== 3'(m_st) || hv_en !== e_hv || pwm_en !== e_pwm || ss_level !== SSW'(m_ss) ||
        fault_latched !== e_lat || fault_cause !== 3'(m_cause)) begin
      errors++;
      $display("FAIL %s model: act st=%0d hv=%b pwm=%b ss=%0d lat=%b cause=%0d exp st=%0d hv=%b pwm=%b ss=%0d lat=%b cause=%0d",
        cur_req, state, hv_en, pwm_en, ss_level, fault_latched, fault_cause,
        m_st, e_hv, e_pwm, m_ss, e_lat, m_cause);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sup_on = 0; sup_pwm = 0; sup_run = 0; sup_ovp = 0; fb_open = 0; out_ovp = 0; otp = 0; gate = 0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic power_up();
    cur_req = "R2";
    sup_run = 1; cyc(2);
    chk(state == 3'd1, "R2", state, 1);
    chk(hv_en == 1'b1, "R1", hv_en, 1);
    sup_pwm = 1; sup_on = 1;
    #1 chk(hv_en == 1'b0, "R1", hv_en, 0);
    cur_req = "R3";
    cyc(SS + 4);
    chk(state == 3'd3, "R3", state, 3);
    chk(ss_level == SSW'(SS), "R3", ss_level, SS);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    cyc(2);
    chk(state == 3'd0, "R2", state, 0);
    chk(hv_en == 1'b1 && pwm_en == 1'b0, "R1", hv_en, 1);
    rst_n = 1'b1; cyc(1);

    // R2: lose shutdown level during startup
    sup_run = 1; cyc(2); sup_run = 0; cyc(2);
    chk(state == 3'd0, "R2", state, 0);
    power_up();

    // R5: open loop glitch then sustained
    cur_req = "R5";
    fb_open = 1; cyc(OLP - 2); fb_open = 0; cyc(1); fb_open = 1; cyc(OLP - 2);
    chk(state == 3'd3, "R5", state, 3);
    cyc(4); fb_open = 0;
    chk(state == 3'd4, "R5", state, 4);
    // R10: fault flags ignored outside active states
    cur_req = "R10";
    otp = 1; sup_ovp = 1; cyc(OVP + 2); otp = 0; sup_ovp = 0;
    chk(fault_latched == 1'b0, "R10", fault_latched, 0);
    // R4: supply sags and recovers above PWM-off only
    cur_req = "R4";
    sup_on = 0; sup_pwm = 0; cyc(3); sup_pwm = 1; cyc(3);
    chk(pwm_en == 1'b0, "R4", pwm_en, 0);
    sup_pwm = 0; sup_run = 0; cyc(2);
    chk(state == 3'd0 && hv_en == 1'b1, "R4", state, 0);
    power_up();
    cur_req = "R4";
    sup_on = 0; sup_pwm = 0; cyc(2);
    chk(state == 3'd4, "R4", state, 4);
    sup_run = 0; cyc(2);

    // R6: supply over-voltage glitch then sustained
    power_up();
    cur_req = "R6";
    sup_ovp = 1; cyc(OVP - 2); sup_ovp = 0; cyc(1); sup_ovp = 1; cyc(OVP - 2);
    chk(fault_latched == 1'b0, "R6", fault_latched, 0);
    cyc(4);
    chk(fault_cause == 3'd1, "R6", fault_cause, 1);
    cur_req = "R9";
    sup_ovp = 0; sup_run = 0; sup_on = 0; sup_pwm = 0; cyc(3); sup_run = 1; sup_pwm = 1; sup_on = 1; cyc(3);
    chk(fault_latched && !pwm_en && !hv_en, "R9", fault_latched, 1);
    do_reset();
    chk(fault_cause == 3'd0, "R9", fault_cause, 0);

    // R7: output over-voltage only counted after blanking with gate low
    power_up();
    cur_req = "R7";
    for (int p = 0; p < 3; p++) begin
      gate = 1; out_ovp = 1; cyc(3);
      gate = 0; out_ovp = 1; cyc(BLANK);
      out_ovp = 0; cyc(10 - BLANK);
    end
    chk(fault_latched == 1'b0, "R7", fault_latched, 0);
    gate = 1; cyc(3); gate = 0; out_ovp = 1; cyc(10);
    out_ovp = 0; gate = 1; cyc(3); gate = 0; out_ovp = 1; cyc(10);
    chk(fault_cause == 3'd2, "R7", fault_cause, 2);
    out_ovp = 0; gate = 0;
    do_reset();

    // R8: over-temperature during soft-start, together with open loop
    cur_req = "R8";
    sup_run = 1; cyc(2); sup_pwm = 1; sup_on = 1; cyc(3);
    fb_open = 1; otp = 1; cyc(2); otp = 0; fb_open = 0;
    chk(fault_cause == 3'd4 && state == 3'd5, "R8", fault_cause, 4);
    do_reset();

    // R9: simultaneous causes recorded together
    power_up();
    cur_req = "R9";
    sup_ovp = 1; cyc(OVP - 1); otp = 1; cyc(2); otp = 0; sup_ovp = 0;
    chk(fault_cause == 3'd5, "R9", fault_cause, 5);
    cyc(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule